// File: doc/BRIEF.md
# SPI Mode-0 Echo Slave

This block is an SPI slave, 8 bits per transfer, that returns each byte it receives. It runs in a fast system clock domain and oversamples the serial clock, the active-low select and the data input. During a transaction it shifts the master's bits into a receive register on rising serial-clock edges. It shifts a transmit register out MSB first, one bit per falling edge. While the slave is deselected, the transmit register keeps reloading from the receive register. So every transaction echoes the byte captured in the one before it. A master under test can therefore check its own send and receive paths against a known target.

Serial inputs pass through a two-stage synchroniser. Edges are found by comparing each synchronised sample with the one before it. A small state machine has three states. `ST_IDLE` is deselected, with the transmit register reloading. `ST_SHIFT` means selected, with bits being counted. `ST_FULL` means all 8 bits have arrived and the slave is waiting for deselect. Its transitions are:
- `ST_IDLE -> ST_SHIFT`, on a falling select edge; this also clears the bit count.
- `ST_SHIFT -> ST_FULL`, on the eighth rising serial-clock edge.
- `ST_SHIFT -> ST_IDLE` and `ST_FULL -> ST_IDLE`, whenever select is high.

When the byte completes, a status register takes the received byte and a done flag pulses for one system clock. The system clock must run at least 8 times the serial clock rate, because the transmit path has about three system clocks of latency.

Top module: `spi_echo_slave`

## Requirements
- R1: After reset the receive, transmit and status registers are 0x00, the done flag is low, and MISO shows 0 in the first transaction.
- R2: On each rising serial-clock edge in the shifting state, the MOSI bit enters the receive register LSB and earlier bits move toward the MSB, so a byte sent MSB first is captured unchanged.
- R3: MISO carries the transmit register MSB; each falling serial-clock edge while selected shifts that register left and fills the LSB with 0.
- R4: While select is high, the transmit register reloads from the receive register, so each transaction sends back the byte captured in the previous one, MSB first.
- R5: After the eighth rising edge of a transaction, the status output takes the received byte and the done flag is high for exactly one system clock; the status output changes at no other time.
- R6: Serial-clock edges while select is high change neither the receive register nor the status output, and produce no done pulse.
- R7: A falling edge of select restarts the bit count; the bits of an aborted (short) transaction stay in the receive register, and the next transaction needs a full 8 new edges before done.
- R8: Rising edges after the eighth in one transaction are ignored by the receive register and produce no further done pulse; MISO shows 0 for those extra bits.
- R9: With the default parameter setting, MISO is driven (never high-impedance), including while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, MSB first |
| rx_status | output | DATA_W (8) | Last completed received byte |
| rx_done | output | 1 | One-cycle pulse per completed byte |

## Verification
A wrong bit count or state shows up at the ports in the same transaction. The done pulse comes early or late, or the status byte is a shifted copy of the sent byte. A corrupted transmit or receive register stays hidden until the next transaction, where the echoed bits on MISO disagree with the byte captured before. So each transaction's check also covers the previous one. Ignored-edge and aborted-transfer faults surface as an unexpected done pulse, a changed status, or a wrong echo on the following transfer.

// File: rtl/spi_echo_pkg.sv
package spi_echo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FULL  = 2'd2
    } echo_state_t;
endpackage

// File: rtl/spi_echo_sync.sv
module spi_echo_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_echo_edge.sv
module spi_echo_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/spi_echo_ctrl.sv
module spi_echo_ctrl
    import spi_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_s,
    input  logic ss_fall,
    input  logic sclk_rise,
    input  logic sclk_fall,
    output logic rx_shift,
    output logic byte_end,
    output logic tx_load,
    output logic tx_shift
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    echo_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ss_fall) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (ss_s)                                state_d = ST_IDLE;
                else if (sclk_rise && cnt_q == LAST_BIT) state_d = ST_FULL;
            end
            ST_FULL:  if (ss_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (ss_fall)  cnt_q <= '0;
        else if (rx_shift) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        rx_shift = (state_q == ST_SHIFT) && sclk_rise;
        byte_end = rx_shift && (cnt_q == LAST_BIT);
        tx_load  = (state_q == ST_IDLE);
        tx_shift = (state_q != ST_IDLE) && sclk_fall;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));

    assert_full_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |=> (state_q == ST_FULL));

    assert_full_holds_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !ss_s) |=> $stable(cnt_q));

    assert_idle_when_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && state_q != ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/spi_echo_shreg.sv
module spi_echo_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mosi_s,
    input  logic              rx_shift,
    input  logic              byte_end,
    input  logic              tx_load,
    input  logic              tx_shift,
    output logic              tx_msb,
    output logic [DATA_W-1:0] status,
    output logic              done
);
    logic [DATA_W-1:0] rx_q, tx_q, status_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= '0;
            tx_q     <= '0;
            status_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (rx_shift) rx_q <= {rx_q[DATA_W-2:0], mosi_s};
            if (tx_load)       tx_q <= rx_q;
            else if (tx_shift) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (byte_end) status_q <= {rx_q[DATA_W-2:0], mosi_s};
            done_q <= byte_end;
        end
    end

    assign tx_msb = tx_q[DATA_W-1];
    assign status = status_q;
    assign done   = done_q;

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_status_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != $past(status_q)) |-> done_q);

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_shift |=> $stable(rx_q));

    assert_tx_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_shift && !tx_load) |=> (tx_q[0] == 1'b0));
endmodule

// File: rtl/spi_echo_slave.sv
module spi_echo_slave #(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter bit TRISTATE_MISO = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [DATA_W-1:0] rx_status,
    output logic              rx_done
);
    logic [2:0] pins_s;
    logic       sclk_s, ss_s, mosi_s;
    logic [1:0] rise_v, fall_v;
    logic       rx_shift, byte_end, tx_load, tx_shift, tx_msb;

    spi_echo_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sclk, spi_ss_n, spi_mosi}),
        .dout  (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign ss_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_echo_edge #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({sclk_s, ss_s}),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    spi_echo_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_s      (ss_s),
        .ss_fall   (fall_v[0]),
        .sclk_rise (rise_v[1]),
        .sclk_fall (fall_v[1]),
        .rx_shift  (rx_shift),
        .byte_end  (byte_end),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift)
    );

    spi_echo_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mosi_s   (mosi_s),
        .rx_shift (rx_shift),
        .byte_end (byte_end),
        .tx_load  (tx_load),
        .tx_shift (tx_shift),
        .tx_msb   (tx_msb),
        .status   (rx_status),
        .done     (rx_done)
    );

    generate
        if (TRISTATE_MISO) begin : g_miso_tri
            assign spi_miso = ss_s ? 1'bz : tx_msb;
        end else begin : g_miso_drv
            assign spi_miso = tx_msb;
        end
    endgenerate
endmodule

// File: tb/spi_echo_slave_tb_top.sv
module spi_echo_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [7:0] status;
    logic       done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int done_rises = 0;
    int done_highs = 0;
    logic done_prev = 1'b0;

    logic [7:0] exp_rx = 8'h00;
    logic [7:0] exp_status = 8'h00;

    always #2.5 clk = ~clk;

    spi_echo_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (sclk),
        .spi_ss_n  (ss_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .rx_status (status),
        .rx_done   (done)
    );

    always @(posedge clk) begin
        if (done === 1'b1) begin
            done_highs++;
            if (done_prev !== 1'b1) done_rises++;
        end
        done_prev <= done;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] shift_in(input logic [7:0] r, input logic b);
        return {r[6:0], b};
    endfunction

    function automatic logic expected_miso(input logic [7:0] echo, input int idx);
        return (idx < 8) ? echo[7-idx] : 1'b0;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transaction: nbits serial-clock cycles, byte sent MSB first.
    task automatic xfer(input logic [7:0] data, input int nbits, input int half);
        logic [7:0] echo;
        int rises0;
        echo = exp_rx;
        rises0 = done_rises;
        ss_n = 1'b0;
        wait_clk(half);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 8) ? data[7-i] : 1'($urandom_range(0, 1));
            check((i < 8) ? "R4 echo bit" : "R8 extra bit zero", 32'(miso), 32'(expected_miso(echo, i)));
            sclk = 1'b1;
            if (i < 8) exp_rx = shift_in(exp_rx, mosi);
            wait_clk(half);
            sclk = 1'b0;
            wait_clk(half);
        end
        ss_n = 1'b1;
        wait_clk(6);
        if (nbits >= 8) begin
            exp_status = exp_rx;
            check("R5 done once per byte", 32'(done_rises - rises0), 32'd1);
        end else begin
            check("R7 no done on short transfer", 32'(done_rises - rises0), 32'd0);
        end
        check("R2 status byte", 32'(status), 32'(exp_status));
        check("R9 miso driven when idle", 32'(miso === 1'bz), 32'd0);
        check("R4 reload while idle", 32'(miso), 32'(exp_rx[7]));
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_clk(4);
        check("R1 reset status", 32'(status), 32'h00);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset miso", 32'(miso), 32'd0);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: first transfer echoes zero; R2 capture
        xfer(8'hA5, 8, 8);
        xfer(8'h3C, 8, 8);
        xfer(8'hFF, 8, 6);
        xfer(8'h00, 8, 6);
        xfer(8'h81, 8, 10);

        // R6: serial clock toggles while deselected
        begin
            int r0;
            r0 = done_rises;
            for (int k = 0; k < 12; k++) begin
                mosi = 1'($urandom_range(0, 1));
                sclk = ~sclk;
                wait_clk(5);
            end
            sclk = 1'b0;
            wait_clk(6);
            check("R6 no done while idle", 32'(done_rises - r0), 32'd0);
            check("R6 status unchanged", 32'(status), 32'(exp_status));
        end
        xfer(8'h5A, 8, 8);  // echo proves rx untouched (R6)

        // R7: aborted transfer then full one
        xfer(8'hC3, 5, 8);
        xfer(8'h96, 8, 8);
        xfer(8'h11, 3, 7);
        xfer(8'h7E, 8, 7);

        // R8: extra edges beyond eight
        xfer(8'hB4, 11, 8);
        xfer(8'h2D, 8, 8);

        // constrained random
        for (int t = 0; t < 40; t++) begin
            int nb;
            nb = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 7)) :
                 ($urandom_range(0, 9) == 0) ? int'($urandom_range(9, 12)) : 8;
            xfer(8'($urandom()), nb, int'($urandom_range(5, 10)));
            wait_clk(int'($urandom_range(0, 5)));
        end

        check("R5 single-cycle done pulses", 32'(done_highs), 32'(done_rises));
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule